// File: doc/BRIEF.md
# Selectable Reference Prescaler with Cascaded Divide-by-N

This block derives a reference edge for a phase comparator from a stream of clock enables. A prescaler counts enables and emits a one-cycle pulse after every 4, 16, 64 or 100 of them. A two-bit select picks the ratio. The ratio of 100 lets a 5 MHz enable stream produce a 50 kHz reference. A second stage is a 4-bit programmable divide-by-N counter. A mode input sets how the two stages relate. In cascade mode the prescaler pulses drive the N stage, so the pair divides by ratio times N. In independent mode the N stage counts its own enable input and the prescaler runs on its own.

Both stages are built on one terminal-count machine with two states. RUN is the reset state and the counting state. WRAP lasts one cycle and drives the output pulse. The machine moves from RUN to WRAP on an enable that arrives while the count equals the latched terminal value. The count then reloads to zero and the new terminal value is captured. From WRAP it returns to RUN on any cycle without a terminal enable. It stays in WRAP only when each enable is itself terminal, which happens for a terminal value of zero (N = 1). Without an enable, RUN holds. The select code and N are sampled only at reset and at each wrap.

Top module: `refdiv_top`

## Requirements
- R1: A synchronous active-high `rst` clears both counters and both pulse outputs. At the same edge it captures `ratio_sel` and `n_val`. A reset edge that coincides with a terminal enable produces no pulse.
- R2: With `ratio_sel` = 00 the prescaler divides by 4. `pre_pulse` is high during the cycle after the clock edge that registered the 4th enable.
- R3: Select code 01 divides by 16, 10 divides by 64 and 11 divides by 100. The prescaler count never exceeds its terminal value.
- R4: `pre_pulse` is never high for two cycles in a row.
- R5: A cycle with the enable low leaves a stage's count unchanged and yields no pulse from that stage.
- R6: A change of `ratio_sel` takes effect only at the next prescaler terminal count. The latched ratio holds between wraps.
- R7: With `chain_mode` = 1 the N stage counts only `pre_pulse` cycles and ignores `n_en`. The pair then divides by ratio times N.
- R8: With `chain_mode` = 0 the N stage counts `n_en` and divides it by N, independent of the prescaler.
- R9: `n_val` = 0 divides by 16. `n_val` = 1 gives an `n_pulse` in the cycle after every counted enable.
- R10: A change of `n_val` takes effect only at the next N-stage terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Enable stream counted by the prescaler |
| ratio_sel | input | 2 | Prescaler ratio: 00 ÷4, 01 ÷16, 10 ÷64, 11 ÷100 |
| chain_mode | input | 1 | 1: N stage counts prescaler pulses; 0: N stage counts n_en |
| n_val | input | 4 | Divide-by-N value; 0 means 16 |
| n_en | input | 1 | Enable stream for the N stage in independent mode |
| pre_pulse | output | 1 | One-cycle reference pulse from the prescaler |
| n_pulse | output | 1 | One-cycle pulse from the divide-by-N stage |

## Verification
A settings change can fall in the same cycle as a terminal count. In that case the new code must be captured at that wrap and not at a later one. The bench provokes this by changing `ratio_sel` in the middle of a ÷4 period. It then checks that the old ratio still ends the current period, and that exactly 100 further enables are needed for the next pulse. The bench applies the same case to `n_val`. Reset can also meet a terminal enable. The bench asserts `rst` on the exact cycle of the 4th enable and checks that no pulse follows and that counting restarts from zero.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    // Two-state terminal-count machine shared by both stages
    typedef enum logic {
        CNT_RUN  = 1'b0,
        CNT_WRAP = 1'b1
    } cnt_state_t;

    // Largest of four ratios, used to size the prescaler count
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/refdiv_term_counter.sv
module refdiv_term_counter
    import refdiv_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] term_in,
    output logic         pulse
);

    cnt_state_t   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] term_q, term_d;
    logic         at_term;

    assign at_term = (cnt_q == term_q);

    // Next-state and datapath
    always_comb begin
        state_d = CNT_RUN;
        cnt_d   = cnt_q;
        term_d  = term_q;
        if (en) begin
            if (at_term) begin
                state_d = CNT_WRAP;
                cnt_d   = '0;
                term_d  = term_in;
            end else begin
                cnt_d   = cnt_q + 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CNT_RUN;
            cnt_q   <= '0;
            term_q  <= term_in;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            term_q  <= term_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            CNT_RUN:  pulse = 1'b0;
            CNT_WRAP: pulse = 1'b1;
            default:  pulse = 1'b0;
        endcase
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= term_q);

    assert_pulse_after_term_R2: assert property (@(posedge clk) disable iff (rst)
        (en && at_term) |=> pulse);

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(cnt_q) && !pulse));

    assert_term_latched_R6: assert property (@(posedge clk) disable iff (rst)
        !(en && at_term) |=> $stable(term_q));

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && !pulse));

endmodule

// File: rtl/refdiv_prescaler.sv
module refdiv_prescaler
    import refdiv_pkg::*;
#(
    parameter int RATIO_0 = 4,
    parameter int RATIO_1 = 16,
    parameter int RATIO_2 = 64,
    parameter int RATIO_3 = 100,
    localparam int RMAX   = max4(RATIO_0, RATIO_1, RATIO_2, RATIO_3),
    localparam int CW     = $clog2(RMAX)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] sel,
    output logic       pulse
);

    logic [CW-1:0] term_sel;

    // Select code to terminal value (ratio - 1)
    always_comb begin
        unique case (sel)
            2'b00:   term_sel = CW'(RATIO_0 - 1);
            2'b01:   term_sel = CW'(RATIO_1 - 1);
            2'b10:   term_sel = CW'(RATIO_2 - 1);
            2'b11:   term_sel = CW'(RATIO_3 - 1);
            default: term_sel = CW'(RATIO_0 - 1);
        endcase
    end

    refdiv_term_counter #(.W(CW)) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .term_in (term_sel),
        .pulse   (pulse)
    );

    // Every ratio is at least 2, so pulses are isolated
    assert_single_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/refdiv_nstage.sv
module refdiv_nstage #(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [NW-1:0] n_val,
    output logic          pulse
);

    logic [NW-1:0] term_n;

    // N = 0 selects the full range 2**NW; otherwise terminal is N - 1
    always_comb begin
        if (n_val == '0) term_n = '1;
        else             term_n = n_val - 1'b1;
    end

    refdiv_term_counter #(.W(NW)) cnt_i (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .term_in (term_n),
        .pulse   (pulse)
    );

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pulse);

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
    parameter int RATIO_0 = 4,
    parameter int RATIO_1 = 16,
    parameter int RATIO_2 = 64,
    parameter int RATIO_3 = 100,
    parameter int NW      = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_en,
    input  logic [1:0]    ratio_sel,
    input  logic          chain_mode,
    input  logic [NW-1:0] n_val,
    input  logic          n_en,
    output logic          pre_pulse,
    output logic          n_pulse
);

    logic nstage_en;

    refdiv_prescaler #(
        .RATIO_0 (RATIO_0),
        .RATIO_1 (RATIO_1),
        .RATIO_2 (RATIO_2),
        .RATIO_3 (RATIO_3)
    ) pre_i (
        .clk   (clk),
        .rst   (rst),
        .en    (cnt_en),
        .sel   (ratio_sel),
        .pulse (pre_pulse)
    );

    // Cascade routes the prescaler pulse into the N stage
    always_comb begin
        unique case (chain_mode)
            1'b1:    nstage_en = pre_pulse;
            1'b0:    nstage_en = n_en;
            default: nstage_en = 1'b0;
        endcase
    end

    refdiv_nstage #(.NW(NW)) nst_i (
        .clk   (clk),
        .rst   (rst),
        .en    (nstage_en),
        .n_val (n_val),
        .pulse (n_pulse)
    );

    assert_chain_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (chain_mode && !pre_pulse) |=> !n_pulse);

    assert_indep_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (!chain_mode && !n_en) |=> !n_pulse);

endmodule

// File: tb/refdiv_top_tb.sv
module refdiv_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int NVEC       = 8;
    // sel, n, chain, enables, expected pre pulses, expected n pulses
    localparam int VEC [NVEC][6] = '{
        '{0, 3, 1,  24, 6, 2},
        '{1, 2, 1,  64, 4, 2},
        '{2, 1, 1, 128, 2, 2},
        '{3, 0, 1, 300, 3, 0},
        '{3, 2, 1, 200, 2, 1},
        '{0, 5, 0,  20, 5, 4},
        '{1, 0, 0,  32, 2, 2},
        '{2, 7, 0,  70, 1, 10}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [1:0] ratio_sel = 2'b00;
    logic       chain_mode = 1'b0;
    logic [3:0] n_val = 4'd1;
    logic       n_en = 1'b0;
    logic       pre_pulse;
    logic       n_pulse;

    int tests  = 0;
    int failed = 0;
    int pre_seen = 0;
    int n_seen = 0;

    refdiv_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .cnt_en     (cnt_en),
        .ratio_sel  (ratio_sel),
        .chain_mode (chain_mode),
        .n_val      (n_val),
        .n_en       (n_en),
        .pre_pulse  (pre_pulse),
        .n_pulse    (n_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Inputs change at the falling edge; outputs sampled one falling edge later
    task automatic step(input logic e, input logic ne);
        cnt_en = e;
        n_en   = ne;
        @(posedge clk);
        @(negedge clk);
        if (pre_pulse) pre_seen++;
        if (n_pulse)   n_seen++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b0, 1'b0);
        rst = 1'b0;
        pre_seen = 0;
        n_seen   = 0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        failed++;
        $display("FAIL watchdog all-reqs actual=expired expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        do_reset();
        check("R1 pre_pulse after reset", int'(pre_pulse), 0);
        check("R1 n_pulse after reset", int'(n_pulse), 0);

        // Table walk: R2 R3 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            ratio_sel  = 2'(VEC[i][0]);
            n_val      = 4'(VEC[i][1]);
            chain_mode = VEC[i][2] != 0;
            do_reset();
            for (int k = 0; k < VEC[i][3]; k++) step(1'b1, 1'b1);
            step(1'b0, 1'b0);
            step(1'b0, 1'b0);
            check($sformatf("R3 R2 vec%0d pre count", i), pre_seen, VEC[i][4]);
            check($sformatf("R7 R8 R9 vec%0d n count", i), n_seen, VEC[i][5]);
        end

        // R2 exact timing, R4 single cycle
        ratio_sel = 2'b00; chain_mode = 1'b0; n_val = 4'd1;
        do_reset();
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
        check("R2 no pulse before 4th enable", int'(pre_pulse), 0);
        step(1'b1, 1'b0);
        check("R2 pulse after 4th enable", int'(pre_pulse), 1);
        step(1'b0, 1'b0);
        check("R4 pulse lasts one cycle", int'(pre_pulse), 0);

        // R5 gaps in the enable stream
        do_reset();
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 1'b0);
            step(1'b0, 1'b0);
        end
        check("R5 gapped enables divide by 4", pre_seen, 2);

        // R6 select change mid-period
        ratio_sel = 2'b00;
        do_reset();
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        ratio_sel = 2'b11;
        step(1'b1, 1'b0); step(1'b1, 1'b0);
        check("R6 old ratio ends current period", pre_seen, 1);
        for (int k = 0; k < 99; k++) step(1'b1, 1'b0);
        check("R6 new ratio not early", pre_seen, 1);
        step(1'b1, 1'b0);
        check("R6 new ratio 100 applied", pre_seen, 2);

        // R10 N change mid-period, R9 pass-through afterwards
        chain_mode = 1'b0; n_val = 4'd3;
        do_reset();
        step(1'b0, 1'b1);
        n_val = 4'd1;
        step(1'b0, 1'b1); step(1'b0, 1'b1);
        check("R10 old N ends current period", n_seen, 1);
        step(1'b0, 1'b1);
        check("R9 N=1 pulse after enable", int'(n_pulse), 1);
        step(1'b0, 1'b0);
        check("R9 N=1 no pulse without enable", int'(n_pulse), 0);
        step(1'b0, 1'b1);
        check("R10 R9 N=1 count", n_seen, 3);

        // R7 n_en ignored in cascade
        chain_mode = 1'b1; n_val = 4'd1; ratio_sel = 2'b00;
        do_reset();
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1);
        check("R7 n_en ignored in cascade", n_seen, 0);

        // R1 reset meets terminal enable
        chain_mode = 1'b0; ratio_sel = 2'b00;
        do_reset();
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
        rst = 1'b1;
        step(1'b1, 1'b0);
        rst = 1'b0;
        check("R1 reset beats terminal", int'(pre_pulse), 0);
        step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
        check("R1 count restarted", pre_seen, 0);
        step(1'b1, 1'b0);
        check("R1 pulse after 4 fresh enables", pre_seen, 1);

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule